// File: doc/BRIEF.md
# Triggered Waveform Accumulator

This block sums a series of triggered waveform records into one accumulation buffer, one sample location at a time. Software sets a record length and a trigger count and then pulses `arm`. After that, each accepted trigger captures a burst of consecutive samples. When the burst ends, the block runs a merge pass. In that pass, location i of the accumulation memory is loaded with sample i if this is the first record of the run. For every later record, sample i is added to location i. When the programmed number of records has been merged, the run ends and the summed record can be read through a registered readout port.

The merge pass takes one clock per sample, and the `dead` output is high for the whole of it. A trigger that arrives during a capture or a merge pass is dropped and is not counted. The trigger count must lie between 1 and 520000, and any value above 8 must be a multiple of 8. Other values are corrected when `arm` is accepted, and `ntrig_fixed` reports that a correction was made.

The controller has five states:
- ST_IDLE goes to ST_WAIT on `arm`.
- ST_WAIT goes to ST_CAPT on `trig`. If the length is 1, it goes straight to ST_MERGE.
- ST_CAPT goes to ST_MERGE after the last sample.
- ST_MERGE goes back to ST_WAIT after the last location if more records are due. Otherwise it goes to ST_DONE.
- ST_DONE goes to ST_WAIT on `arm`.

Top module: `wave_avg`

## Requirements
- R1: While reset is applied, `busy`, `dead`, `done`, `ntrig_fixed` and `rd_data` are all 0.
- R2: `arm` is accepted only in ST_IDLE or ST_DONE. On acceptance the block latches the length and the trigger count, and `busy` is 1 from the next cycle. An `arm` pulse while `busy` is 1 has no effect. A length of 0 is taken as 1, and a length above DEPTH is taken as DEPTH.
- R3: A trigger accepted in ST_WAIT captures the sample present in that same cycle as index 0. The following length−1 cycles supply indexes 1 up to length−1.
- R4: The first record of a run overwrites locations 0 to length−1. Each later record adds its sign-extended 12-bit two's-complement samples to the 32-bit two's-complement contents.
- R5: After each capture, `dead` is 1 for exactly length cycles. A trigger that arrives during a capture or while `dead` is 1 is dropped and is not counted.
- R6: The requested trigger count is adjusted as follows:
  - 1 to 8 is used as given, with `ntrig_fixed` = 0.
  - 0 becomes 1, with `ntrig_fixed` = 1.
  - 9 to 520000 that is not a multiple of 8 is rounded down to a multiple of 8, with `ntrig_fixed` = 1.
  - Above 520000 becomes 520000, with `ntrig_fixed` = 1.
- R7: `done` becomes 1, and `busy` 0, right after the merge of the last counted record. In ST_DONE, triggers are ignored and the buffer is left unchanged.
- R8: `rd_data` shows the accumulation location addressed by `rd_addr` one clock later.
- R9: A new `arm` accepted from ST_DONE starts a fresh run. Its first record replaces the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_len | input | LEN_W | Record length in samples, latched on arm |
| cfg_ntrig | input | TRIG_W | Requested trigger count, latched on arm |
| arm | input | 1 | Starts a run |
| trig | input | 1 | Trigger pulse |
| smp_in | input | SMP_W | Signed sample stream |
| rd_addr | input | AW | Readout address |
| rd_data | output | ACC_W | Registered accumulation readout |
| busy | output | 1 | Run in progress |
| dead | output | 1 | Merge pass running; triggers are dropped |
| done | output | 1 | Accumulated record is complete |
| ntrig_fixed | output | 1 | Trigger count was adjusted at arm |

## Verification
The bench builds the block with DEPTH = 16, so a full-buffer record and an over-long length request can both be reached in a few dozen cycles. All other parameters keep their defaults: a 20-bit trigger count with a ceiling of 520000, 12-bit samples and a 32-bit accumulator. With these values the bench can check every rounding branch through the flag, and can check counts of 7 and of 13 rounded to 8 through the cycle in which `done` rises. Single-sample records keep these multi-record runs short.

// File: rtl/wave_avg_pkg.sv
package wave_avg_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_CAPT,
        ST_MERGE,
        ST_DONE
    } avg_state_e;
endpackage

// File: rtl/avg_trig_rule.sv
module avg_trig_rule #(
    parameter int TRIG_W   = 20,
    parameter int MAX_TRIG = 520000
) (
    input  logic [TRIG_W-1:0] raw,
    output logic [TRIG_W-1:0] tgt,
    output logic              fixed
);
    localparam int CEIL = (MAX_TRIG > 8) ? (MAX_TRIG / 8) * 8 : MAX_TRIG;

    always_comb begin
        if (raw == '0) begin
            tgt   = TRIG_W'(1);
            fixed = 1'b1;
        end else if (raw > TRIG_W'(CEIL)) begin
            tgt   = TRIG_W'(CEIL);
            fixed = 1'b1;
        end else if (raw > TRIG_W'(8) && raw[2:0] != 3'b000) begin
            tgt   = {raw[TRIG_W-1:3], 3'b000};
            fixed = 1'b1;
        end else begin
            tgt   = raw;
            fixed = 1'b0;
        end
    end
endmodule

// File: rtl/avg_cap_buf.sv
module avg_cap_buf #(
    parameter int DEPTH = 64,
    parameter int W     = 12,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/avg_acc_ram.sv
module avg_acc_ram #(
    parameter int DEPTH = 64,
    parameter int W     = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] mrd_addr,
    output logic [W-1:0]  mrd_data,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign mrd_data = mem[mrd_addr];

    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/wave_avg.sv
module wave_avg
    import wave_avg_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int SMP_W    = 12,
    parameter int ACC_W    = 32,
    parameter int TRIG_W   = 20,
    parameter int MAX_TRIG = 520000,
    localparam int AW      = $clog2(DEPTH),
    localparam int LEN_W   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [TRIG_W-1:0] cfg_ntrig,
    input  logic              arm,
    input  logic              trig,
    input  logic [SMP_W-1:0]  smp_in,
    input  logic [AW-1:0]     rd_addr,
    output logic [ACC_W-1:0]  rd_data,
    output logic              busy,
    output logic              dead,
    output logic              done,
    output logic              ntrig_fixed
);
    avg_state_e         state, state_nx;
    logic [LEN_W-1:0]   len_q, len_eff;
    logic [TRIG_W-1:0]  tgt_q, rec_q, tgt_w;
    logic [AW-1:0]      idx_q;
    logic               fixed_q, fixed_w, idx_last, last_rec;
    logic               cap_we;
    logic [AW-1:0]      cap_waddr;
    logic [SMP_W-1:0]   cap_rd;
    logic [ACC_W-1:0]   acc_old, acc_new, smp_ext;

    avg_trig_rule #(.TRIG_W(TRIG_W), .MAX_TRIG(MAX_TRIG)) u_rule (
        .raw(cfg_ntrig), .tgt(tgt_w), .fixed(fixed_w)
    );

    always_comb begin
        if (cfg_len == '0)                    len_eff = LEN_W'(1);
        else if (cfg_len > LEN_W'(DEPTH))     len_eff = LEN_W'(DEPTH);
        else                                  len_eff = cfg_len;
    end

    assign idx_last = (LEN_W'(idx_q) == len_q - LEN_W'(1));
    assign last_rec = ((rec_q + TRIG_W'(1)) == tgt_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE, ST_DONE: if (arm) state_nx = ST_WAIT;
            ST_WAIT:  if (trig) state_nx = (len_q == LEN_W'(1)) ? ST_MERGE : ST_CAPT;
            ST_CAPT:  if (idx_last) state_nx = ST_MERGE;
            ST_MERGE: if (idx_last) state_nx = last_rec ? ST_DONE : ST_WAIT;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q   <= LEN_W'(1);
            tgt_q   <= TRIG_W'(1);
            rec_q   <= '0;
            idx_q   <= '0;
            fixed_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE, ST_DONE: if (arm) begin
                    len_q   <= len_eff;
                    tgt_q   <= tgt_w;
                    fixed_q <= fixed_w;
                    rec_q   <= '0;
                    idx_q   <= '0;
                end
                ST_WAIT: if (trig) idx_q <= (len_q == LEN_W'(1)) ? '0 : AW'(1);
                ST_CAPT: idx_q <= idx_last ? '0 : idx_q + AW'(1);
                ST_MERGE: begin
                    idx_q <= idx_last ? '0 : idx_q + AW'(1);
                    if (idx_last) rec_q <= rec_q + TRIG_W'(1);
                end
                default: ;
            endcase
        end
    end

    // outputs and memory controls
    always_comb begin
        busy        = (state == ST_WAIT) || (state == ST_CAPT) || (state == ST_MERGE);
        dead        = (state == ST_MERGE);
        done        = (state == ST_DONE);
        ntrig_fixed = fixed_q;
        cap_we      = ((state == ST_WAIT) && trig) || (state == ST_CAPT);
        cap_waddr   = (state == ST_WAIT) ? '0 : idx_q;
        smp_ext     = {{(ACC_W-SMP_W){cap_rd[SMP_W-1]}}, cap_rd};
        acc_new     = (rec_q == '0) ? smp_ext : acc_old + smp_ext;
    end

    avg_cap_buf #(.DEPTH(DEPTH), .W(SMP_W), .AW(AW)) u_cap (
        .clk(clk), .we(cap_we), .waddr(cap_waddr), .wdata(smp_in),
        .raddr(idx_q), .rdata(cap_rd)
    );

    avg_acc_ram #(.DEPTH(DEPTH), .W(ACC_W), .AW(AW)) u_acc (
        .clk(clk), .rst_n(rst_n), .wr_en(dead), .wr_addr(idx_q), .wr_data(acc_new),
        .mrd_addr(idx_q), .mrd_data(acc_old), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // R2: busy only rises after an accepted arm
    a_r2_arm_starts: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(arm));
    // R3: capture index stays inside the latched length
    a_r3_capt_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CAPT) |-> (LEN_W'(idx_q) < len_q));
    // R5: merge pass is not cut short
    a_r5_dead_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dead && !idx_last) |=> dead);
    // R5: dead and done never overlap
    a_r5_dead_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(dead && done));
    // R6: latched target obeys the count rules
    a_r6_target_legal: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (tgt_q != '0 && tgt_q <= TRIG_W'(MAX_TRIG) && (tgt_q <= TRIG_W'(8) || tgt_q[2:0] == 3'b000)));
    // R4: record counter stays below target during a run
    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rec_q < tgt_q));
    // R7: done holds until re-armed
    a_r7_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !arm) |=> done);
endmodule

// File: tb/wave_avg_tb.sv
`timescale 1ns/1ps
module wave_avg_tb;
    localparam int DEPTH = 16;
    localparam int AW    = $clog2(DEPTH);
    localparam int LEN_W = $clog2(DEPTH + 1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic [LEN_W-1:0] cfg_len = '0;
    logic [19:0] cfg_ntrig = '0;
    logic arm = 1'b0, trig = 1'b0;
    logic [11:0] smp_in = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic busy, dead, done, ntrig_fixed;

    int n_chk = 0, n_bad = 0;
    int exp_acc [DEPTH];

    always #2.5 clk = ~clk;

    wave_avg #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_ntrig(cfg_ntrig),
        .arm(arm), .trig(trig), .smp_in(smp_in), .rd_addr(rd_addr),
        .rd_data(rd_data), .busy(busy), .dead(dead), .done(done),
        .ntrig_fixed(ntrig_fixed)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int smp_val(input int r, input int k);
        if (r == 0 && k == 0) return -2048;
        if (r == 1 && k == 0) return 2047;
        return ((r * 131 + k * 57) % 1000) - 500;
    endfunction

    task automatic do_arm(input int len, input int n);
        @(negedge clk);
        cfg_len = LEN_W'(len); cfg_ntrig = 20'(n); arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
    endtask

    // one record: trigger with sample 0, then the rest; inj pulses extra triggers to be dropped
    task automatic send_rec(input int len, input int r, input bit first, input bit inj, output int dcnt);
        int v;
        @(negedge clk);
        v = smp_val(r, 0); trig = 1'b1; smp_in = v[11:0];
        exp_acc[0] = first ? v : exp_acc[0] + v;
        for (int k = 1; k < len; k++) begin
            @(negedge clk);
            v = smp_val(r, k); smp_in = v[11:0];
            trig = (inj && k == 1);
            exp_acc[k] = first ? v : exp_acc[k] + v;
        end
        @(negedge clk);
        trig = 1'b0; smp_in = 12'h5A5;
        dcnt = 0;
        while (dead && dcnt < 100) begin
            trig = (inj && dcnt == 1);
            dcnt++;
            @(negedge clk);
        end
        trig = 1'b0;
    endtask

    task automatic read_chk(input int addr, input int expv, input string req);
        @(negedge clk);
        rd_addr = AW'(addr);
        @(negedge clk);
        chk($signed(rd_data) == expv, req, $signed(rd_data), expv);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!busy && !dead && !done && !ntrig_fixed, "R1 status", {busy, dead, done, ntrig_fixed}, 0);
        chk(rd_data == 0, "R1 rd_data", rd_data, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_basic();
        int d;
        do_arm(4, 3);
        chk(busy == 1'b1, "R2 busy after arm", busy, 1);
        chk(ntrig_fixed == 1'b0, "R6 count 3 unchanged", ntrig_fixed, 0);
        for (int r = 0; r < 3; r++) begin
            send_rec(4, r, r == 0, 1'b0, d);
            chk(d == 4, "R5 dead length 4", d, 4);
            chk(done == (r == 2), "R7 done timing", done, r == 2);
        end
        chk(busy == 1'b0, "R7 busy low at done", busy, 0);
        for (int k = 0; k < 4; k++) read_chk(k, exp_acc[k], "R3 R4 R8 sum");
    endtask

    task automatic t_drop();
        int d;
        do_arm(5, 2);
        send_rec(5, 5, 1'b1, 1'b1, d);
        chk(d == 5, "R5 dead length 5", d, 5);
        chk(done == 1'b0, "R5 dropped trigger not counted", done, 0);
        send_rec(5, 6, 1'b0, 1'b0, d);
        chk(done == 1'b1, "R5 done after two counted", done, 1);
        for (int k = 0; k < 5; k++) read_chk(k, exp_acc[k], "R5 sum without dropped");
        // trigger while done: ignored
        @(negedge clk); trig = 1'b1; smp_in = 12'h7FF;
        @(negedge clk); trig = 1'b0;
        repeat (8) @(negedge clk);
        chk(done == 1'b1, "R7 still done", done, 1);
        for (int k = 0; k < 5; k++) read_chk(k, exp_acc[k], "R7 buffer unchanged");
    endtask

    task automatic t_rearm();
        int d;
        do_arm(20, 1);
        @(negedge clk); cfg_len = LEN_W'(2); arm = 1'b1;
        @(negedge clk); arm = 1'b0;
        send_rec(16, 9, 1'b1, 1'b0, d);
        chk(d == 16, "R2 length clamp and arm ignored when busy", d, 16);
        chk(done == 1'b1, "R9 single record run done", done, 1);
        read_chk(0, exp_acc[0], "R9 overwrite loc0");
        read_chk(15, exp_acc[15], "R9 overwrite loc15");
    endtask

    task automatic t_counts();
        int d;
        do_arm(1, 13);
        chk(ntrig_fixed == 1'b1, "R6 13 flagged", ntrig_fixed, 1);
        for (int r = 0; r < 8; r++) begin
            send_rec(1, r + 2, r == 0, 1'b0, d);
            if (r == 6) chk(done == 1'b0, "R6 not done after 7", done, 0);
        end
        chk(done == 1'b1, "R6 13 rounds to 8", done, 1);
        read_chk(0, exp_acc[0], "R6 eight-record sum");
        do_arm(0, 0);
        chk(ntrig_fixed == 1'b1, "R6 zero flagged", ntrig_fixed, 1);
        send_rec(1, 3, 1'b1, 1'b0, d);
        chk(d == 1, "R2 length 0 taken as 1", d, 1);
        chk(done == 1'b1, "R6 zero becomes one", done, 1);
        do_arm(1, 7);
        chk(ntrig_fixed == 1'b0, "R6 7 unchanged", ntrig_fixed, 0);
        for (int r = 0; r < 7; r++) send_rec(1, r, r == 0, 1'b0, d);
        chk(done == 1'b1, "R6 done after 7", done, 1);
        do_arm(1, 600000);
        chk(ntrig_fixed == 1'b1, "R6 above ceiling flagged", ntrig_fixed, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_drop();
        t_rearm();
        t_counts();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule